// File: doc/BRIEF.md
# DDR2 Data-Window Latency Sequencer

This block sits in a memory-controller datapath after column-command issue. Each cycle it may receive one read or write column command that has already gone to the memory. It works out the interface clocks in which that command's data occupies the bus. Read data appears after the read latency. Read latency is the additive latency plus the CAS latency. Write data appears one clock earlier than read data would. A burst of 4 or 8 beats is carried on both clock edges, so it lasts 2 or 4 clocks.

The block keeps a shift-register map of future bus occupancy, with one lane per direction. It produces a per-cycle capture enable for reads and a per-cycle drive enable for writes. It also gives the timing of a complementary strobe pair: a low preamble clock before the first beat, high/low toggling during beats, and a half-clock low postamble after the last beat. A new command is refused and flagged if its window would overlap an existing one. It is also refused if it would touch an opposite-direction window without one idle clock between them. Configuration writes take effect only while nothing is scheduled, and only with legal values.

Top module: `rwlat_sched`

## Requirements
- R1: A configuration write is accepted only if the CAS latency is 3, 4 or 5 and the additive latency is 0 to 4. Any other value pulses `cfg_rej_o` in the cycle after the write and leaves the settings unchanged.
- R2: A configuration write is also refused, in the same way, if any data window is still scheduled or current, or if a command is presented in the same cycle.
- R3: A read sampled at clock edge E drives `rd_cap_o` high in the cycles that start at edge E+AL+CL.
- R4: A write sampled at edge E drives `wr_drv_o` high in the cycles that start at edge E+AL+CL-1.
- R5: A window lasts 2 clocks with `cfg_bl8_i`=0 (4 beats) and 4 clocks with `cfg_bl8_i`=1 (8 beats).
- R6: A command whose window overlaps a scheduled window of the same direction is discarded, and `conflict_o` pulses in the cycle after it is sampled.
- R7: Read and write windows need at least one idle clock between them. A command that breaks this rule is discarded and `conflict_o` pulses. `rd_cap_o` and `wr_drv_o` are never high together.
- R8: Same-direction windows may abut with no gap. The enable then stays high across both windows, with no conflict and no strobe preamble between them.
- R9: In the idle clock just before a window, the strobe is driven (`dqs_oe_o`=1) with `dqs_o`=0 and `dqs_n_o`=1.
- R10: In the first idle clock after a window, `dqs_post_o`=1 and the strobe is driven low, unless a preamble falls in that clock. In that case the preamble takes the clock and `dqs_post_o`=0.
- R11: `dqs_o` is high exactly in data clocks. While `dqs_oe_o`=1, `dqs_n_o` is the complement of `dqs_o`. While `dqs_oe_o`=0, both strobe outputs are 0.
- R12: After reset all outputs are 0, and the configuration is CAS latency 3, additive latency 0, burst of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_cl_i | input | 3 | CAS latency to program |
| cfg_al_i | input | 3 | Additive latency to program |
| cfg_bl8_i | input | 1 | 1 selects 8-beat bursts, 0 selects 4-beat bursts |
| cfg_rej_o | output | 1 | Pulses when a configuration write is refused |
| cmd_vld_i | input | 1 | Column command issued this cycle |
| cmd_wr_i | input | 1 | 1 for a write, 0 for a read |
| conflict_o | output | 1 | Pulses when the previous command was refused |
| rd_cap_o | output | 1 | Read data capture enable for this clock |
| wr_drv_o | output | 1 | Write data drive enable for this clock |
| dqs_o | output | 1 | True strobe level for the first half of this clock |
| dqs_n_o | output | 1 | Complement strobe level while driven |
| dqs_oe_o | output | 1 | Strobe pair driven in this clock |
| dqs_post_o | output | 1 | Postamble clock: drive low for its first half only |

## Verification
The bench aims at the latency arithmetic at its corners: additive latency 4 with CAS latency 5, and the write path one clock short of the read path. A design that added latencies wrongly or gave writes a fixed latency would move the enables by whole clocks. It also tests windows that sit exactly one clock apart, abut, or overlap, in the same direction and across a turnaround. An off-by-one guard would either accept a read-write collision or refuse a legal back-to-back stream. Configuration writes are tried with illegal values and while a burst is pending. Later latency measurements show whether a refused write still changed the settings. The strobe is compared every clock, including the idle clock where a postamble and a preamble compete, where a wrong priority shows up as a half-driven preamble.

// File: rtl/rwlat_pkg.sv
package rwlat_pkg;
  typedef struct packed {
    logic [2:0] cl;
    logic [2:0] al;
    logic       bl8;
  } lat_cfg_t;

  localparam lat_cfg_t CFG_RST = '{cl: 3'd3, al: 3'd0, bl8: 1'b0};
endpackage

// File: rtl/rwlat_cfg.sv
module rwlat_cfg import rwlat_pkg::*; #(
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 5,
  parameter int AL_MAX = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [2:0] cl_i,
  input  logic [2:0] al_i,
  input  logic       bl8_i,
  input  logic       idle_i,
  output lat_cfg_t   cfg_o,
  output logic       rej_o
);
  localparam logic [2:0] CL_LO = 3'(CL_MIN);
  localparam logic [2:0] CL_HI = 3'(CL_MAX);
  localparam logic [2:0] AL_HI = 3'(AL_MAX);

  logic legal, take;

  assign legal = (cl_i >= CL_LO) && (cl_i <= CL_HI) && (al_i <= AL_HI);
  assign take  = we_i && legal && idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= CFG_RST;
      rej_o <= 1'b0;
    end else begin
      rej_o <= we_i && !take;
      if (take) cfg_o <= '{cl: cl_i, al: al_i, bl8: bl8_i};
    end
  end
endmodule

// File: rtl/rwlat_occ.sv
module rwlat_occ import rwlat_pkg::*; #(
  parameter int DEPTH = 15
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cmd_vld_i,
  input  logic     cmd_wr_i,
  input  lat_cfg_t cfg_i,
  output logic     cur_rd_o,
  output logic     cur_wr_o,
  output logic     nxt_any_o,
  output logic     busy_o,
  output logic     conflict_o
);
  logic [DEPTH-1:0] occ_rd_q, occ_wr_q, sh_rd, sh_wr, win, grd;
  logic hit, acc;
  int rl, lat, nb;

  assign sh_rd = occ_rd_q >> 1;
  assign sh_wr = occ_wr_q >> 1;

  always_comb begin
    rl  = int'(cfg_i.al) + int'(cfg_i.cl);
    lat = cmd_wr_i ? rl - 1 : rl;
    nb  = cfg_i.bl8 ? 4 : 2;
    for (int i = 0; i < DEPTH; i++) begin
      win[i] = (i >= lat) && (i < lat + nb);
      // window widened by one clock each side for turnaround
      grd[i] = (i + 1 >= lat) && (i <= lat + nb);
    end
  end

  always_comb begin
    if (cmd_wr_i) hit = |(sh_wr & win) || |(sh_rd & grd);
    else          hit = |(sh_rd & win) || |(sh_wr & grd);
  end

  assign acc = cmd_vld_i && !hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_rd_q   <= '0;
      occ_wr_q   <= '0;
      conflict_o <= 1'b0;
    end else begin
      occ_rd_q   <= sh_rd | ((acc && !cmd_wr_i) ? win : '0);
      occ_wr_q   <= sh_wr | ((acc &&  cmd_wr_i) ? win : '0);
      conflict_o <= cmd_vld_i && hit;
    end
  end

  assign cur_rd_o  = occ_rd_q[0];
  assign cur_wr_o  = occ_wr_q[0];
  assign nxt_any_o = occ_rd_q[1] | occ_wr_q[1];
  assign busy_o    = |(occ_rd_q | occ_wr_q);
endmodule

// File: rtl/rwlat_strobe.sv
module rwlat_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cur_i,
  input  logic nxt_i,
  output logic dqs_o,
  output logic dqs_n_o,
  output logic dqs_oe_o,
  output logic dqs_post_o
);
  logic last_q, pre;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= cur_i;
  end

  // preamble owns a shared idle clock over the postamble
  assign pre        = !cur_i && nxt_i;
  assign dqs_post_o = !cur_i && last_q && !pre;
  assign dqs_oe_o   = cur_i || pre || dqs_post_o;
  assign dqs_o      = cur_i;
  assign dqs_n_o    = dqs_oe_o && !cur_i;
endmodule

// File: rtl/rwlat_sched.sv
module rwlat_sched import rwlat_pkg::*; #(
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 5,
  parameter int AL_MAX = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic [2:0] cfg_cl_i,
  input  logic [2:0] cfg_al_i,
  input  logic       cfg_bl8_i,
  output logic       cfg_rej_o,
  input  logic       cmd_vld_i,
  input  logic       cmd_wr_i,
  output logic       conflict_o,
  output logic       rd_cap_o,
  output logic       wr_drv_o,
  output logic       dqs_o,
  output logic       dqs_n_o,
  output logic       dqs_oe_o,
  output logic       dqs_post_o
);
  localparam int BURST_CLK_MAX = 4;
  localparam int DEPTH = AL_MAX + CL_MAX + BURST_CLK_MAX + 2;

  lat_cfg_t cfg_q;
  logic nxt_any, busy, idle;

  assign idle = !busy && !cmd_vld_i;

  rwlat_cfg #(.CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .AL_MAX(AL_MAX)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .cl_i(cfg_cl_i), .al_i(cfg_al_i), .bl8_i(cfg_bl8_i),
    .idle_i(idle), .cfg_o(cfg_q), .rej_o(cfg_rej_o)
  );

  rwlat_occ #(.DEPTH(DEPTH)) u_occ (
    .clk_i, .rst_ni,
    .cmd_vld_i, .cmd_wr_i, .cfg_i(cfg_q),
    .cur_rd_o(rd_cap_o), .cur_wr_o(wr_drv_o), .nxt_any_o(nxt_any),
    .busy_o(busy), .conflict_o
  );

  rwlat_strobe u_dqs (
    .clk_i, .rst_ni,
    .cur_i(rd_cap_o || wr_drv_o), .nxt_i(nxt_any),
    .dqs_o, .dqs_n_o, .dqs_oe_o, .dqs_post_o
  );
endmodule

// File: rtl/rwlat_chk.sv
module rwlat_chk import rwlat_pkg::*; (
  input logic     clk_i,
  input logic     rst_ni,
  input logic     cfg_rej_o,
  input logic     rd_cap_o,
  input logic     wr_drv_o,
  input logic     dqs_o,
  input logic     dqs_n_o,
  input logic     dqs_oe_o,
  input logic     dqs_post_o,
  input lat_cfg_t cfg_q
);
  AST_REJ_KEEPS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rej_o |-> $stable(cfg_q)); // R1
  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_cap_o && wr_drv_o)); // R7
  AST_RD_TO_WR_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cap_o |=> !wr_drv_o); // R7
  AST_WR_TO_RD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_drv_o |=> !rd_cap_o); // R7
  AST_PREAMBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dqs_o) |-> $past(dqs_oe_o) && $past(dqs_n_o)); // R9
  AST_POSTAMBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dqs_o) |-> dqs_oe_o); // R10
  AST_DQS_COMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqs_oe_o |-> (dqs_n_o == !dqs_o)); // R11
  AST_DQS_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dqs_oe_o |-> (!dqs_o && !dqs_n_o && !dqs_post_o)); // R11
  AST_DATA_ONLY_DQS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqs_o == (rd_cap_o || wr_drv_o)); // R11
endmodule

bind rwlat_sched rwlat_chk u_chk (
  .clk_i, .rst_ni, .cfg_rej_o, .rd_cap_o, .wr_drv_o,
  .dqs_o, .dqs_n_o, .dqs_oe_o, .dqs_post_o, .cfg_q
);

// File: tb/rwlat_sched_test.sv
module rwlat_sched_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_bl8 = 1'b0, cmd_vld = 1'b0, cmd_wr = 1'b0;
  logic [2:0] cfg_cl = 3'd3, cfg_al = 3'd0;
  logic cfg_rej, conflict, rd_cap, wr_drv, dqs, dqs_n, dqs_oe, dqs_post;

  always #5 clk = ~clk;

  rwlat_sched uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_cl_i(cfg_cl), .cfg_al_i(cfg_al), .cfg_bl8_i(cfg_bl8),
    .cfg_rej_o(cfg_rej), .cmd_vld_i(cmd_vld), .cmd_wr_i(cmd_wr),
    .conflict_o(conflict), .rd_cap_o(rd_cap), .wr_drv_o(wr_drv),
    .dqs_o(dqs), .dqs_n_o(dqs_n), .dqs_oe_o(dqs_oe), .dqs_post_o(dqs_post)
  );

  int errors = 0, checks = 0, conf_seen = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  localparam int N = 8192;
  bit rd_at [N];
  bit wr_at [N];
  bit conf_at [N];
  bit rej_at [N];
  int e = 0;
  int m_cl = 3, m_al = 0, m_bl8 = 0;

  function automatic bit any_at(input int j);
    if (j < 0 || j >= N) return 1'b0;
    return rd_at[j] | wr_at[j];
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      e++;
      if (cmd_vld) begin
        int l, n;
        bit hit;
        l = m_al + m_cl - (cmd_wr ? 1 : 0);
        n = m_bl8 ? 4 : 2;
        hit = 0;
        for (int j = e + l; j < e + l + n; j++)
          if (cmd_wr ? wr_at[j] : rd_at[j]) hit = 1;
        for (int j = e + l - 1; j <= e + l + n; j++)
          if (cmd_wr ? rd_at[j] : wr_at[j]) hit = 1;
        conf_at[e] = hit;
        if (!hit)
          for (int j = e + l; j < e + l + n; j++)
            if (cmd_wr) wr_at[j] = 1; else rd_at[j] = 1;
      end
      if (cfg_we) begin
        bit busy;
        busy = cmd_vld;
        for (int j = e - 1; j < e + 24; j++) if (any_at(j)) busy = 1;
        if (!busy && cfg_cl >= 3 && cfg_cl <= 5 && cfg_al <= 4) begin
          m_cl = int'(cfg_cl); m_al = int'(cfg_al); m_bl8 = int'(cfg_bl8);
        end else rej_at[e] = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit pre, post, oe;
      pre  = !any_at(e) && any_at(e + 1);
      post = !any_at(e) && any_at(e - 1) && !pre;
      oe   = any_at(e) || pre || post;
      chk(rd_cap == rd_at[e], "R3 rd_cap", int'(rd_cap), int'(rd_at[e]));
      chk(wr_drv == wr_at[e], "R4 wr_drv", int'(wr_drv), int'(wr_at[e]));
      chk(conflict == conf_at[e], "R6 conflict", int'(conflict), int'(conf_at[e]));
      chk(cfg_rej == rej_at[e], "R1 cfg_rej", int'(cfg_rej), int'(rej_at[e]));
      chk(dqs_oe == oe, "R9 dqs_oe", int'(dqs_oe), int'(oe));
      chk(dqs_post == post, "R10 dqs_post", int'(dqs_post), int'(post));
      chk(dqs == any_at(e), "R11 dqs", int'(dqs), int'(any_at(e)));
      chk(dqs_n == (oe && !any_at(e)), "R11 dqs_n", int'(dqs_n), int'(oe && !any_at(e)));
      if (conflict) conf_seen++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input bit wr);
    @(negedge clk); cmd_vld = 1; cmd_wr = wr;
    @(negedge clk); cmd_vld = 0;
  endtask

  task automatic set_cfg(input int cl, input int al, input bit bl8);
    @(negedge clk); cfg_we = 1; cfg_cl = 3'(cl); cfg_al = 3'(al); cfg_bl8 = bl8;
    @(negedge clk); cfg_we = 0;
  endtask

  // issues one command and measures its window, preamble and postamble
  task automatic measure(input bit wr, output int lat, output int len,
                         output bit pre_ok, output bit post_ok);
    bit oe_k [32];
    bit dq_k [32];
    bit po_k [32];
    @(negedge clk); cmd_vld = 1; cmd_wr = wr;
    @(negedge clk); cmd_vld = 0;
    lat = -1; len = 0;
    for (int k = 0; k < 32; k++) begin
      oe_k[k] = dqs_oe; dq_k[k] = dqs; po_k[k] = dqs_post;
      if (wr ? wr_drv : rd_cap) begin
        if (lat < 0) lat = k;
        len++;
      end
      @(negedge clk);
    end
    pre_ok  = (lat > 0) && oe_k[lat-1] && !dq_k[lat-1];
    post_ok = (lat >= 0) && (lat + len < 32) && po_k[lat+len] && oe_k[lat+len];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lat, len, c0, cnt;
    bit pr, po;
    wait_clk(3);
    // R12 reset state
    chk({rd_cap, wr_drv, dqs, dqs_n, dqs_oe, dqs_post, conflict, cfg_rej} == 8'b0,
        "R12 reset outputs", int'({rd_cap, wr_drv, dqs, dqs_n, dqs_oe, dqs_post, conflict, cfg_rej}), 0);
    rst_n = 1;
    wait_clk(2);

    // R12 default config: CL3 AL0 BL4
    measure(0, lat, len, pr, po);
    chk(lat == 3, "R12 default read latency", lat, 3);
    chk(len == 2, "R5 burst 4 length", len, 2);
    chk(pr, "R9 read preamble", int'(pr), 1);
    chk(po, "R10 read postamble", int'(po), 1);
    measure(1, lat, len, pr, po);
    chk(lat == 2, "R4 default write latency", lat, 2);

    // CL5 AL2 BL8: read 7, write 6
    set_cfg(5, 2, 1);
    measure(0, lat, len, pr, po);
    chk(lat == 7, "R3 read latency AL2 CL5", lat, 7);
    chk(len == 4, "R5 burst 8 length", len, 4);
    measure(1, lat, len, pr, po);
    chk(lat == 6, "R4 write latency AL2 CL5", lat, 6);
    chk(pr && po, "R9 write strobe framing", int'(pr && po), 1);

    // R1 illegal values leave settings unchanged
    set_cfg(2, 0, 0);
    set_cfg(6, 0, 0);
    set_cfg(3, 5, 0);
    measure(0, lat, len, pr, po);
    chk(lat == 7 && len == 4, "R1 illegal cfg ignored", lat, 7);

    // R2 cfg while a burst is scheduled is refused
    issue(0);
    set_cfg(3, 0, 0);
    wait_clk(16);
    measure(0, lat, len, pr, po);
    chk(lat == 7, "R2 busy cfg ignored", lat, 7);

    // R6 overlapping reads, one clock apart
    c0 = conf_seen;
    @(negedge clk); cmd_vld = 1; cmd_wr = 0;
    @(negedge clk);
    @(negedge clk); cmd_vld = 0;
    cnt = 0;
    for (int k = 0; k < 20; k++) begin if (rd_cap) cnt++; @(negedge clk); end
    chk(conf_seen - c0 == 1, "R6 overlap flagged", conf_seen - c0, 1);
    chk(cnt == 4, "R6 second read discarded", cnt, 4);

    // R8 abutting reads, 4 clocks apart
    c0 = conf_seen;
    issue(0); wait_clk(2); issue(0);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin if (rd_cap) cnt++; @(negedge clk); end
    chk(conf_seen == c0, "R8 abutting no conflict", conf_seen - c0, 0);
    chk(cnt == 8, "R8 continuous capture", cnt, 8);

    // R7 read then write adjacent (spacing 5) conflicts, spacing 6 accepted
    c0 = conf_seen;
    issue(0); wait_clk(3); issue(1);
    wait_clk(20);
    chk(conf_seen - c0 == 1, "R7 no-gap turnaround refused", conf_seen - c0, 1);
    c0 = conf_seen;
    issue(0); wait_clk(4); issue(1);
    cnt = 0;
    for (int k = 0; k < 24; k++) begin if (wr_drv) cnt++; @(negedge clk); end
    chk(conf_seen == c0, "R7 one-gap turnaround ok", conf_seen - c0, 0);
    chk(cnt == 4, "R7 write after gap", cnt, 4);

    // AL4 CL5 extremes
    set_cfg(5, 4, 0);
    measure(0, lat, len, pr, po);
    chk(lat == 9, "R3 read latency AL4 CL5", lat, 9);
    measure(1, lat, len, pr, po);
    chk(lat == 8, "R4 write latency AL4 CL5", lat, 8);

    // random traffic, compared every clock by the model
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      cmd_vld = ($urandom_range(0, 2) == 0);
      cmd_wr  = $urandom_range(0, 1) == 1;
      cfg_we  = ($urandom_range(0, 40) == 0);
      cfg_cl  = 3'($urandom_range(2, 6));
      cfg_al  = 3'($urandom_range(0, 5));
      cfg_bl8 = $urandom_range(0, 1) == 1;
      if (cfg_we && $urandom_range(0, 1) == 1) cmd_vld = 0;
    end
    @(negedge clk); cmd_vld = 0; cfg_we = 0;
    wait_clk(20);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule